// File: doc/BRIEF.md
# Zero-Order-Hold Multibit Sigma-Delta Modulator with Element Rotation

This block is the last digital stage in front of a unit-element converter. Samples arrive from an upstream interpolator at a low rate, each marked by a one-cycle valid strobe. The block holds each sample in a register, so the loop sees the same value on every modulator step until the next strobe replaces it. With strobes every 16 modulator steps, each sample is therefore repeated 16 times.

On each cycle where the modulator enable is high, a second-order noise-shaping loop with a 6-bit quantizer makes one step. Feedback enters the first integrator with weight 1 and the second with weight 2. The resulting code, 0 to 63, turns on that many of 63 equal output elements. A rotating start pointer walks the elements, so over time every element is used equally often and static mismatch between elements is shaped away from the signal band. An overload flag reports integrator clipping.

Top module: `zsd_modulator`

## Requirements
- R1: A synchronous active-high `rst` clears the held sample, both integrators, the rotation pointer, `code`, `elem_on` and `overload` to zero on the next rising edge.
- R2: When `smp_valid` is high at a rising edge, `smp_data` is stored in the hold register. The loop uses the value held before that edge, so a strobe coinciding with a modulator step takes effect from the following step.
- R3: On edges where `mod_en` is low, `code`, `elem_on` and `overload` keep their values and the loop state does not move.
- R4: Each step computes u = smp_held + 2^15 (offset binary) and F = code_new * 2^10. It then updates i1' = i1 + u - F and i2' = i2 + i1 - 2F, with both integrators 20-bit two's complement.
- R5: code_new = floor((i2 + 512) / 1024), limited to 0..63, using i2 before the step. It appears on `code` one edge after the step.
- R6: The number of ones in `elem_on` always equals `code`.
- R7: The pointer starts at 0 and advances by code_new modulo 63 on each step. The elements that are on are bits (ptr + k) mod 63 for k = 0..code_new-1, using the pointer before the step.
- R8: A result outside -2^19..2^19-1 is clipped to the nearest limit. `overload` is set for a step in which either integrator clipped and cleared for a step in which neither did.
- R9: With a constant in-range input, the mean of `code` over a long run equals u/1024 within one code step.
- R10: Since reset, the per-element on-counts after any step differ by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_en | input | 1 | Modulator step enable |
| smp_valid | input | 1 | Strobe for a new interpolated sample |
| smp_data | input | 16 | Two's complement sample |
| elem_on | output | 63 | Unit-element enables |
| code | output | 6 | Quantized code of the last step |
| overload | output | 1 | Integrator clipped in the last step |

## Verification
Every output is registered. A step sampled on one rising edge therefore shows its code, element vector and overload flag right after that edge, and a held sample first reaches the outputs one step after the edge that loaded it. The bench updates its behavioural model on the same edge the design uses and compares all outputs at the following falling edge, on every clock. This covers cycles with the enable low, strobes that coincide with steps, and both integrator limits. Averages and element-usage balance are judged from the observed outputs over windows of whole steps.

// File: rtl/zsd_pkg.sv
package zsd_pkg;
    // default widths shared by the modulator stages
    localparam int ZSD_IN_W   = 16;
    localparam int ZSD_CODE_W = 6;
    localparam int ZSD_GUARD  = 4;

    // outcome of a saturating integrator update
    typedef enum logic [1:0] {
        CLIP_NONE = 2'd0,
        CLIP_HI   = 2'd1,
        CLIP_LO   = 2'd2
    } clip_e;
endpackage

// File: rtl/zsd_hold.sv
module zsd_hold #(
    parameter int IN_W = zsd_pkg::ZSD_IN_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [IN_W-1:0] din,
    output logic [IN_W-1:0] held
);
    typedef struct packed {
        logic [IN_W-1:0] smp;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) st_d.smp = din;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign held = st_q.smp;
endmodule

// File: rtl/zsd_loop.sv
module zsd_loop
    import zsd_pkg::*;
#(
    parameter int IN_W   = ZSD_IN_W,
    parameter int CODE_W = ZSD_CODE_W,
    parameter int GUARD  = ZSD_GUARD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [IN_W-1:0]   held,
    output logic [CODE_W-1:0] q_now,
    output logic [CODE_W-1:0] code_q,
    output logic              ovl_q
);
    localparam int INT_W = IN_W + GUARD;
    localparam int FB_SH = IN_W - CODE_W;
    localparam int SUM_W = INT_W + 3;
    localparam logic [CODE_W-1:0]       MAXC   = '1;
    localparam logic signed [SUM_W-1:0] MAXC_X = SUM_W'(2**CODE_W - 1);
    localparam logic signed [SUM_W-1:0] HALF   = SUM_W'(2**(FB_SH-1));
    localparam logic signed [SUM_W-1:0] LIM_HI =
        {{(SUM_W-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] LIM_LO =
        {{(SUM_W-INT_W+1){1'b1}}, {(INT_W-1){1'b0}}};

    typedef struct packed {
        logic signed [INT_W-1:0] i1;
        logic signed [INT_W-1:0] i2;
        logic [CODE_W-1:0]       code;
        logic                    ovl;
    } loop_t;

    loop_t st_d, st_q;

    function automatic clip_e clip_kind(input logic signed [SUM_W-1:0] v);
        if (v > LIM_HI)      return CLIP_HI;
        else if (v < LIM_LO) return CLIP_LO;
        else                 return CLIP_NONE;
    endfunction

    function automatic logic signed [INT_W-1:0] clip_val(input logic signed [SUM_W-1:0] v);
        logic signed [SUM_W-1:0] r;
        if (v > LIM_HI)      r = LIM_HI;
        else if (v < LIM_LO) r = LIM_LO;
        else                 r = v;
        return r[INT_W-1:0];
    endfunction

    logic signed [SUM_W-1:0] i1_x, i2_x, u_x, rnd, fb, s1, s2;
    logic [IN_W-1:0]   u_off;
    logic [CODE_W-1:0] qc;
    clip_e             k1, k2;

    always_comb begin
        st_d  = st_q;
        u_off = {~held[IN_W-1], held[IN_W-2:0]};
        i1_x  = SUM_W'(st_q.i1);
        i2_x  = SUM_W'(st_q.i2);
        u_x   = signed'({{(SUM_W-IN_W){1'b0}}, u_off});
        rnd   = (i2_x + HALF) >>> FB_SH;
        if (rnd < 0)           qc = '0;
        else if (rnd > MAXC_X) qc = MAXC;
        else                   qc = rnd[CODE_W-1:0];
        fb = signed'({{(SUM_W-CODE_W){1'b0}}, qc}) <<< FB_SH;
        s1 = i1_x + u_x - fb;
        s2 = i2_x + i1_x - (fb <<< 1);
        k1 = clip_kind(s1);
        k2 = clip_kind(s2);
        if (step) begin
            st_d.i1   = clip_val(s1);
            st_d.i2   = clip_val(s2);
            st_d.code = qc;
            st_d.ovl  = (k1 != CLIP_NONE) || (k2 != CLIP_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q_now  = qc;
    assign code_q = st_q.code;
    assign ovl_q  = st_q.ovl;
endmodule

// File: rtl/zsd_rotator.sv
module zsd_rotator #(
    parameter int CODE_W = zsd_pkg::ZSD_CODE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step,
    input  logic [CODE_W-1:0]        code_in,
    output logic [(1<<CODE_W)-2:0]   elem_q
);
    localparam int N = (1 << CODE_W) - 1;
    localparam logic [CODE_W:0] NX = (CODE_W+1)'(N);

    typedef struct packed {
        logic [CODE_W-1:0] ptr;
        logic [N-1:0]      elem;
    } rot_t;

    rot_t st_d, st_q;
    logic [N-1:0]  therm_w;
    logic [CODE_W:0] ptr_sum;

    for (genvar j = 0; j < N; j++) begin : g_elem
        localparam logic [CODE_W:0] JV = (CODE_W+1)'(j);
        logic [CODE_W:0] off;
        always_comb begin
            if (JV >= {1'b0, st_q.ptr}) off = JV - {1'b0, st_q.ptr};
            else                        off = JV + NX - {1'b0, st_q.ptr};
        end
        assign therm_w[j] = (off < {1'b0, code_in});
    end

    always_comb begin
        st_d    = st_q;
        ptr_sum = {1'b0, st_q.ptr} + {1'b0, code_in};
        if (ptr_sum >= NX) ptr_sum = ptr_sum - NX;
        if (step) begin
            st_d.elem = therm_w;
            st_d.ptr  = ptr_sum[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign elem_q = st_q.elem;
endmodule

// File: rtl/zsd_modulator.sv
module zsd_modulator
    import zsd_pkg::*;
#(
    parameter int IN_W   = ZSD_IN_W,
    parameter int CODE_W = ZSD_CODE_W,
    parameter int GUARD  = ZSD_GUARD
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mod_en,
    input  logic                   smp_valid,
    input  logic [IN_W-1:0]        smp_data,
    output logic [(1<<CODE_W)-2:0] elem_on,
    output logic [CODE_W-1:0]      code,
    output logic                   overload
);
    logic [IN_W-1:0]   held_w;
    logic [CODE_W-1:0] q_now_w;

    zsd_hold #(.IN_W(IN_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (smp_valid),
        .din  (smp_data),
        .held (held_w)
    );

    zsd_loop #(.IN_W(IN_W), .CODE_W(CODE_W), .GUARD(GUARD)) u_loop (
        .clk    (clk),
        .rst    (rst),
        .step   (mod_en),
        .held   (held_w),
        .q_now  (q_now_w),
        .code_q (code),
        .ovl_q  (overload)
    );

    zsd_rotator #(.CODE_W(CODE_W)) u_rot (
        .clk     (clk),
        .rst     (rst),
        .step    (mod_en),
        .code_in (q_now_w),
        .elem_q  (elem_on)
    );
endmodule

// File: rtl/zsd_modulator_chk.sv
module zsd_modulator_chk #(
    parameter int IN_W   = zsd_pkg::ZSD_IN_W,
    parameter int CODE_W = zsd_pkg::ZSD_CODE_W
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   mod_en,
    input logic                   smp_valid,
    input logic [IN_W-1:0]        smp_data,
    input logic [IN_W-1:0]        held_w,
    input logic [(1<<CODE_W)-2:0] elem_on,
    input logic [CODE_W-1:0]      code,
    input logic                   overload
);
    logic rst_seen_q;

    always_ff @(posedge clk) rst_seen_q <= rst;

    // R1: the edge after a reset edge shows a cleared block
    always @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_clear_R1: assert (code == '0 && elem_on == '0 &&
                                           !overload && held_w == '0)
                else $error("reset state not clear");
        end
    end

    assert_hold_load_R2: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> held_w == $past(smp_data));

    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !mod_en |=> ($stable(code) && $stable(elem_on) && $stable(overload)));

    assert_count_match_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(elem_on) == int'(code));
endmodule

bind zsd_modulator zsd_modulator_chk #(.IN_W(IN_W), .CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mod_en    (mod_en),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .held_w    (held_w),
    .elem_on   (elem_on),
    .code      (code),
    .overload  (overload)
);

// File: tb/zsd_modulator_test.sv
`timescale 1ns/1ps
module zsd_modulator_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_en = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [62:0] elem_on;
    logic [5:0]  code;
    logic        overload;

    always #2 clk = ~clk;

    zsd_modulator uut (
        .clk(clk), .rst(rst), .mod_en(mod_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .elem_on(elem_on), .code(code), .overload(overload)
    );

    int errors = 0, checks = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on the same edges as the design
    longint m_i1, m_i2, m_hold, m_u, m_t, m_fb, m_n1, m_n2;
    int     m_code, m_ptr, m_c;
    logic   m_ovl;
    logic [62:0] m_elem;
    bit     model_live = 1'b0;
    bit     last_tick = 1'b0;
    localparam longint LIM_HI = 524287;
    localparam longint LIM_LO = -524288;

    always @(posedge clk) begin
        last_tick = 1'b0;
        if (rst) begin
            m_i1 = 0; m_i2 = 0; m_hold = 0; m_code = 0; m_ptr = 0;
            m_ovl = 1'b0; m_elem = '0; model_live = 1'b1;
        end else begin
            if (mod_en) begin
                last_tick = 1'b1;
                m_u = m_hold + 32768;
                m_t = m_i2 + 512;
                if (m_t < 0) m_c = 0;
                else begin
                    m_c = int'(m_t / 1024);
                    if (m_c > 63) m_c = 63;
                end
                m_elem = '0;
                for (int k = 0; k < m_c; k++) m_elem[(m_ptr + k) % 63] = 1'b1;
                m_fb = longint'(m_c) * 1024;
                m_n1 = m_i1 + m_u - m_fb;
                m_n2 = m_i2 + m_i1 - 2 * m_fb;
                m_ovl = (m_n1 > LIM_HI) || (m_n1 < LIM_LO) ||
                        (m_n2 > LIM_HI) || (m_n2 < LIM_LO);
                m_i1 = (m_n1 > LIM_HI) ? LIM_HI : (m_n1 < LIM_LO) ? LIM_LO : m_n1;
                m_i2 = (m_n2 > LIM_HI) ? LIM_HI : (m_n2 < LIM_LO) ? LIM_LO : m_n2;
                m_ptr = (m_ptr + m_c) % 63;
                m_code = m_c;
            end
            if (smp_valid) m_hold = longint'($signed(smp_data));
        end
    end

    // observed-output bookkeeping
    int     ucount [63];
    longint sum_code;
    int     n_meas;
    bit     meas_on = 1'b0;
    bit     saw_ovl = 1'b0;

    always @(negedge clk) begin
        if (model_live && !done) begin
            chk(code == m_code[5:0], "R2 R4 R5 code", longint'(code), longint'(m_code));
            chk(elem_on == m_elem, "R7 elements", longint'({1'b0, elem_on}),
                longint'({1'b0, m_elem}));
            chk(overload == m_ovl, "R8 overload", longint'(overload), longint'(m_ovl));
            chk($countones(elem_on) == int'(code), "R6 ones count",
                longint'($countones(elem_on)), longint'(code));
            if (overload) saw_ovl = 1'b1;
            if (rst) begin
                for (int e = 0; e < 63; e++) ucount[e] = 0;
            end else if (last_tick) begin
                for (int e = 0; e < 63; e++) if (elem_on[e]) ucount[e]++;
                if (meas_on) begin
                    sum_code += longint'(code);
                    n_meas++;
                end
            end
        end
    end

    // stimulus
    int     cyc = 0;
    int     mode = 0;
    longint cur_x = 0;

    task automatic run(input int n, input int vphase, input bit en);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mod_en    = en && (cyc % 4 == 3);
            smp_valid = (cyc % 64 == vphase);
            if (mode == 1) smp_data = 16'(((cyc * 37) % 40000) - 20000);
            else           smp_data = 16'(cur_x);
            cyc++;
        end
    endtask

    task automatic check_avg(input longint x);
        real avg, expv;
        sum_code = 0; n_meas = 0;
        mode = 0; cur_x = x;
        run(800, 0, 1'b1);
        meas_on = 1'b1;
        run(8000, 0, 1'b1);
        meas_on = 1'b0;
        avg  = real'(sum_code) / real'(n_meas);
        expv = real'(x + 32768) / 1024.0;
        chk((avg - expv <= 1.0) && (expv - avg <= 1.0), "R9 average",
            longint'(avg * 1000.0), longint'(expv * 1000.0));
    endtask

    task automatic check_balance();
        int mx, mn;
        mx = ucount[0]; mn = ucount[0];
        for (int e = 1; e < 63; e++) begin
            if (ucount[e] > mx) mx = ucount[e];
            if (ucount[e] < mn) mn = ucount[e];
        end
        chk(mx - mn <= 1, "R10 usage spread", longint'(mx - mn), 1);
    endtask

    task automatic check_reset_state();
        chk(code == 0, "R1 code", longint'(code), 0);
        chk(elem_on == '0, "R1 elements", longint'($countones(elem_on)), 0);
        chk(overload == 1'b0, "R1 overload", longint'(overload), 0);
    endtask

    logic [5:0]  hold_code;
    logic [62:0] hold_elem;

    initial begin
        rst = 1'b1;
        run(3, 0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_reset_state();
        // R9 at several levels across the range
        check_avg(-24000);
        check_avg(-5000);
        check_avg(0);
        check_avg(9000);
        check_avg(26000);
        check_balance();
        // R2: strobes coinciding with steps, changing data
        mode = 1;
        run(8000, 3, 1'b1);
        check_balance();
        // R3: enable held low while samples keep arriving
        @(negedge clk);
        hold_code = code; hold_elem = elem_on;
        run(400, 0, 1'b0);
        @(negedge clk);
        chk(code == hold_code, "R3 code frozen", longint'(code), longint'(hold_code));
        chk(elem_on == hold_elem, "R3 elements frozen",
            longint'($countones(elem_on)), longint'($countones(hold_elem)));
        run(400, 0, 1'b1);
        // R8: full-scale input drives the integrators into their limits
        mode = 0; cur_x = 32767; saw_ovl = 1'b0;
        run(6000, 0, 1'b1);
        chk(saw_ovl, "R8 overload seen", longint'(saw_ovl), 1);
        cur_x = 0;
        run(4000, 0, 1'b1);
        // R1: reset in the middle of activity
        rst = 1'b1;
        run(2, 0, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check_reset_state();
        mode = 1;
        run(2000, 0, 1'b1);
        check_balance();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule